// File: doc/BRIEF.md
# Drive Seek and Disk-Change Tracker

This block keeps the present cylinder of one floppy-style drive and the disk-change flag that software reads in bit 7 of a status byte. A command sequencer hands it one seek at a time. The seek is either an absolute target cylinder or a relative count with a direction. A relative seek toward the spindle (inward) adds the count to the present cylinder. A relative seek toward track 0 (outward) subtracts it. The block then moves the head one cylinder per clock cycle, emitting one step pulse per cylinder crossed. After the last step it raises a one-cycle completion strobe so the sequencer can raise its interrupt.

The disk-change latch is set while the drive holds no media, which covers both an eject and a drive that was empty from the start. It is cleared only by a real step pulse issued while media is present. Reading the status byte has no effect on it. A seek to the cylinder the head already sits on issues no pulse, so it leaves the flag set.

Top module: `drive_seek_tracker`

## Requirements
- R1: After reset the present cylinder is 0, busy and step are low, and disk-change reads 1.
- R2: The status byte carries disk-change in bit 7 and zeros in bits 6..0. While media is absent the flag is 1 in the cycle after that is sampled, whatever seeks run.
- R3: A seek whose target equals the present cylinder issues no step pulse and leaves a set disk-change flag set. The flag changes only through the rules in R2 and R4.
- R4: A step pulse issued while media is present clears disk-change in the following cycle.
- R5: A seek issues exactly |target − present| step pulses, one per cycle in consecutive cycles. `stepInward` is 1 during a pulse toward a higher cylinder and 0 otherwise.
- R6: An absolute seek loads its target value directly; targets above MAX_CYL (default 255) are limited to MAX_CYL.
- R7: An inward relative seek adds the count, saturating at MAX_CYL. An outward one subtracts it, saturating at 0. From 0, inward 1 then outward 1 gives 1 then 0.
- R8: `seekDone` is high for exactly one cycle, the cycle after the last step (or the first busy cycle for a zero-distance seek), with `presentCyl` already final.
- R9: A request is taken only when `busy` is low; requests raised while busy are ignored.
- R10: The cycle after a request is taken, `busy` is 1 and the first step pulse (if any) is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Seek request, taken when idle |
| reqRelative | input | 1 | 1: relative step count, 0: absolute cylinder |
| reqInward | input | 1 | Relative direction, 1 toward higher cylinders |
| reqValue | input | CYL_W | Target cylinder or step count |
| mediaPresent | input | 1 | Media is in the drive |
| busy | output | 1 | Seek in progress |
| stepPulse | output | 1 | One step of the head this cycle |
| stepInward | output | 1 | Direction of the current step |
| seekDone | output | 1 | One-cycle seek completion strobe |
| presentCyl | output | CYL_W | Present cylinder number |
| statusByte | output | 8 | Bit 7 disk-change, other bits 0 |

## Verification
A request raised before a clock edge makes `busy` and the first step visible after that edge. Each following edge moves `presentCyl` by one, and `seekDone` appears in the cycle after the last step. Disk-change reacts one edge after the step or the media level that drives it. The bench keeps a behavioural model that advances on the same edge as the design and compares every output at the falling edge, after the rising-edge update has settled and before new stimulus is applied. Directed checks count the pulses of each seek and sample the cylinder and flag in the `seekDone` cycle or two cycles after a media change.

// File: rtl/seek_pkg.sv
package seek_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadTarget;
    logic stepEn;
  } seekStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } seekStateT;

endpackage

// File: rtl/seek_datapath.sv
module seek_datapath
  import seek_pkg::*;
#(
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  seekStrobeT       strobe,
  input  logic             reqRelative,
  input  logic             reqInward,
  input  logic [CYL_W-1:0] reqValue,
  output logic [CYL_W-1:0] presentCyl,
  output logic             atTarget,
  output logic             moveInward
);

  localparam int SUM_W = CYL_W + 1;
  localparam logic [SUM_W-1:0] LIMIT_S = SUM_W'(MAX_CYL);
  localparam logic [CYL_W-1:0] LIMIT_C = LIMIT_S[CYL_W-1:0];

  logic [CYL_W-1:0] cylQ;
  logic [CYL_W-1:0] targetQ;
  logic [CYL_W-1:0] targetD;
  logic [CYL_W-1:0] absTarget;
  logic [SUM_W-1:0] inSum;

  // Absolute clamp only exists when the limit is below the field range
  generate
    if (MAX_CYL >= (1 << CYL_W) - 1) begin : g_noClamp
      assign absTarget = reqValue;
    end else begin : g_clamp
      assign absTarget = ({1'b0, reqValue} > LIMIT_S) ? LIMIT_C : reqValue;
    end
  endgenerate

  always_comb begin
    inSum = {1'b0, cylQ} + {1'b0, reqValue};
    if (!reqRelative) begin
      targetD = absTarget;
    end else if (reqInward) begin
      targetD = (inSum > LIMIT_S) ? LIMIT_C : inSum[CYL_W-1:0];
    end else begin
      targetD = (reqValue > cylQ) ? '0 : cylQ - reqValue;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cylQ    <= '0;
      targetQ <= '0;
    end else begin
      if (strobe.loadTarget) begin
        targetQ <= targetD;
      end
      if (strobe.stepEn) begin
        cylQ <= moveInward ? cylQ + 1'b1 : cylQ - 1'b1;
      end
    end
  end

  assign presentCyl = cylQ;
  assign atTarget   = (cylQ == targetQ);
  assign moveInward = (targetQ > cylQ);

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepEn |=> (cylQ != $past(cylQ)));  // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, cylQ} <= LIMIT_S));  // R7

endmodule

// File: rtl/seek_control.sv
module seek_control
  import seek_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       atTarget,
  input  logic [7:0] cylProbe,
  output seekStrobeT strobe,
  output logic       busy,
  output logic       stepPulse,
  output logic       seekDone
);

  seekStateT stateQ;
  seekStateT stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_MOVE;
      ST_MOVE: if (atTarget) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign busy              = (stateQ == ST_MOVE);
  assign stepPulse         = busy && !atTarget;
  assign seekDone          = busy && atTarget;
  assign strobe.loadTarget = !busy && reqValid;
  assign strobe.stepEn     = stepPulse;

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);  // R10

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    seekDone |=> (!busy && $stable(cylProbe)));  // R8

endmodule

// File: rtl/dchg_latch.sv
module dchg_latch (
  input  logic clk,
  input  logic rstN,
  input  logic mediaPresent,
  input  logic stepPulse,
  output logic diskChange
);

  logic flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b1;
    end else if (!mediaPresent) begin
      flagQ <= 1'b1;
    end else if (stepPulse) begin
      flagQ <= 1'b0;
    end
  end

  assign diskChange = flagQ;

  AST_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    !mediaPresent |=> diskChange);  // R2

  AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stepPulse && mediaPresent) |=> !diskChange);  // R4

  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (diskChange && !stepPulse) |=> diskChange);  // R3

endmodule

// File: rtl/drive_seek_tracker.sv
module drive_seek_tracker
  import seek_pkg::*;
#(
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRelative,
  input  logic             reqInward,
  input  logic [CYL_W-1:0] reqValue,
  input  logic             mediaPresent,
  output logic             busy,
  output logic             stepPulse,
  output logic             stepInward,
  output logic             seekDone,
  output logic [CYL_W-1:0] presentCyl,
  output logic [7:0]       statusByte
);

  localparam int FLAG_BIT = 7;

  seekStrobeT strobe;
  logic       atTarget;
  logic       moveInward;
  logic       diskChange;
  logic [7:0] cylProbe;

  seek_datapath #(
    .CYL_W  (CYL_W),
    .MAX_CYL(MAX_CYL)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqRelative(reqRelative),
    .reqInward  (reqInward),
    .reqValue   (reqValue),
    .presentCyl (presentCyl),
    .atTarget   (atTarget),
    .moveInward (moveInward)
  );

  assign cylProbe = 8'(presentCyl);

  seek_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .atTarget (atTarget),
    .cylProbe (cylProbe),
    .strobe   (strobe),
    .busy     (busy),
    .stepPulse(stepPulse),
    .seekDone (seekDone)
  );

  dchg_latch u_flag (
    .clk         (clk),
    .rstN        (rstN),
    .mediaPresent(mediaPresent),
    .stepPulse   (stepPulse),
    .diskChange  (diskChange)
  );

  assign stepInward = stepPulse && moveInward;

  always_comb begin
    statusByte           = '0;
    statusByte[FLAG_BIT] = diskChange;
  end

endmodule

// File: tb/sim_drive_seek_tracker.sv
`timescale 1ns/1ps
module sim_drive_seek_tracker;

  localparam int CW   = 8;
  localparam int MAXC = 255;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqRelative = 1'b0;
  logic          reqInward = 1'b0;
  logic [CW-1:0] reqValue = '0;
  logic          mediaPresent = 1'b0;
  logic          busy, stepPulse, stepInward, seekDone;
  logic [CW-1:0] presentCyl;
  logic [7:0]    statusByte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit modelOn = 0;

  // behavioural reference state
  int  mBusy = 0;
  int  mCyl = 0;
  int  mTgt = 0;
  int  mFlag = 1;

  always #2.5 clk = ~clk;

  drive_seek_tracker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRelative(reqRelative),
    .reqInward(reqInward), .reqValue(reqValue), .mediaPresent(mediaPresent),
    .busy(busy), .stepPulse(stepPulse), .stepInward(stepInward),
    .seekDone(seekDone), .presentCyl(presentCyl), .statusByte(statusByte)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  function automatic int calcTarget(int rel, int inw, int v, int cyl);
    if (rel == 0) return (v > MAXC) ? MAXC : v;
    if (inw != 0) return (cyl + v > MAXC) ? MAXC : cyl + v;
    return (v > cyl) ? 0 : cyl - v;
  endfunction

  // model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mCyl = 0; mTgt = 0; mFlag = 1;
    end else begin
      int stepE;
      stepE = (mBusy != 0 && mCyl != mTgt) ? 1 : 0;
      if (!mediaPresent) mFlag = 1;
      else if (stepE != 0) mFlag = 0;
      if (mBusy == 0) begin
        if (reqValid) begin
          mTgt  = calcTarget(int'(reqRelative), int'(reqInward), int'(reqValue), mCyl);
          mBusy = 1;
        end
      end else if (stepE != 0) begin
        mCyl = (mTgt > mCyl) ? mCyl + 1 : mCyl - 1;
      end else begin
        mBusy = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      int eStep;
      eStep = (mBusy != 0 && mCyl != mTgt) ? 1 : 0;
      check("R8 presentCyl", int'(presentCyl), mCyl);
      check("R9 busy", int'(busy), mBusy);
      check("R5 stepPulse", int'(stepPulse), eStep);
      check("R5 stepInward", int'(stepInward), (eStep != 0 && mTgt > mCyl) ? 1 : 0);
      check("R8 seekDone", int'(seekDone), (mBusy != 0 && mCyl == mTgt) ? 1 : 0);
      check("R2 statusByte", int'(statusByte), mFlag * 128);
    end
  end

  // one seek; counts pulses and checks result in the done cycle
  task automatic doSeek(input bit rel, input bit inw, input int val,
                        input int expCyl, input int expSteps, input bit intrude);
    int cnt;
    @(negedge clk);
    #1;
    reqValid = 1'b1; reqRelative = rel; reqInward = inw; reqValue = CW'(val);
    @(negedge clk);
    check("R10 busy after accept", int'(busy), 1);
    check("R10 first step", int'(stepPulse), (expSteps != 0) ? 1 : 0);
    #1 reqValid = 1'b0;
    cnt = 0;
    while (!seekDone) begin
      if (stepPulse) cnt++;
      @(negedge clk);
      #1;
      if (intrude && cnt == 3) begin
        reqValid = 1'b1; reqRelative = 1'b0; reqValue = CW'(200);
      end else begin
        reqValid = 1'b0;
      end
      #0;
    end
    reqValid = 1'b0;
    check("R5 pulse count", cnt, expSteps);
    check("R8 final cylinder", int'(presentCyl), expCyl);
    check("R8 done one cycle", int'(seekDone), 1);
    @(negedge clk);
    check("R8 done drops", int'(seekDone), 0);
    check("R9 idle after done", int'(busy), 0);
  endtask

  task automatic setMedia(input bit present);
    @(negedge clk);
    #1 mediaPresent = present;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cylinder", int'(presentCyl), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset step", int'(stepPulse), 0);
    check("R1 reset flag", int'(statusByte), 8'h80);
    #1 rstN = 1'b1;
    modelOn = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 empty flag stays", int'(statusByte), 8'h80);
    check("R3 repeated read", int'(statusByte), 8'h80);

    // empty drive: a real step must not clear the flag
    doSeek(1'b0, 1'b0, 1, 1, 1, 1'b0);
    check("R2 empty after step", int'(statusByte), 8'h80);
    doSeek(1'b0, 1'b0, 0, 0, 1, 1'b0);

    // insert media: zero-distance seek keeps the flag
    setMedia(1'b1);
    check("R3 insert keeps flag", int'(statusByte), 8'h80);
    doSeek(1'b0, 1'b0, 0, 0, 0, 1'b0);
    check("R3 zero seek keeps flag", int'(statusByte), 8'h80);

    // real step with media clears it
    doSeek(1'b0, 1'b0, 1, 1, 1, 1'b0);
    check("R4 step clears flag", int'(statusByte), 0);
    doSeek(1'b0, 1'b0, 0, 0, 1, 1'b0);

    // relative seeks
    doSeek(1'b1, 1'b1, 1, 1, 1, 1'b0);
    check("R7 inward by one", int'(presentCyl), 1);
    doSeek(1'b1, 1'b0, 1, 0, 1, 1'b0);
    check("R7 outward by one", int'(presentCyl), 0);
    doSeek(1'b1, 1'b0, 5, 0, 0, 1'b0);
    check("R7 outward saturates", int'(presentCyl), 0);
    doSeek(1'b0, 1'b0, 250, 250, 250, 1'b0);
    check("R6 absolute target", int'(presentCyl), 250);
    doSeek(1'b1, 1'b1, 10, 255, 5, 1'b0);
    check("R7 inward saturates", int'(presentCyl), 255);

    // request raised while busy is dropped
    doSeek(1'b0, 1'b0, 20, 20, 235, 1'b1);
    check("R9 busy request ignored", int'(presentCyl), 20);

    // eject sets the flag; seeks keep it set
    setMedia(1'b0);
    check("R2 eject sets flag", int'(statusByte), 8'h80);
    doSeek(1'b0, 1'b0, 23, 23, 3, 1'b0);
    check("R2 empty seek keeps flag", int'(statusByte), 8'h80);
    doSeek(1'b1, 1'b0, 3, 20, 3, 1'b0);
    check("R2 relative keeps flag", int'(statusByte), 8'h80);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule